// File: doc/BRIEF.md
# UART Interrupt Identifier

This block sits beside the register file of a 16550-compatible serial port and decides which interrupt the port reports. It takes four interrupt sources: a line-status error event, a received-data-ready level, a transmit-holding-empty level and a modem-status change event. It combines them with a 4-bit enable field and produces the identification byte that software reads, together with the interrupt request pin.

Only the most urgent enabled source is encoded in the byte. The request pin is gated by the OUT2 modem-control bit. The block stores the two event sources and the transmit-empty condition itself. Each of these clears through its own acknowledge path. The transmit-empty source is also acknowledged when software reads the identification byte while that source is the one shown.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable field mapping: `int_en[0]` enables received data, `int_en[1]` enables transmit-holding-empty, `int_en[2]` enables line-status error and `int_en[3]` enables modem change. A disabled source is neither reported in `ident` nor drives `irq`.
- R2: `ident[0]` is 1 when no enabled source is pending and 0 when one is pending.
- R3: `ident[2:1]` encodes the reported source as 11 for line-status error, 10 for received data, 01 for transmit-holding-empty and 00 for modem change. `ident[5:3]` always read 0.
- R4: Priority from highest to lowest is line status, then received data, then transmit-holding-empty, then modem change. Only the highest pending enabled source is reported.
- R5: `ident[7:6]` read 11 when `fifo_on` is 1 and 00 when it is 0.
- R6: `irq` is 1 exactly when `out2` is 1 and an enabled source is pending.
- R7: A cycle with `ident_read` high while `ident[2:0]` shows 010 clears the transmit-empty source from the next cycle on. An `ident_read` while another source is shown leaves it pending.
- R8: The transmit-empty source is raised in the cycle after `hold_empty` rises. It is cleared in the cycle after `hold_write`.
- R9: A 0-to-1 change of `int_en[1]` while `hold_empty` is 1 raises the transmit-empty source in the next cycle.
- R10: A `line_err` pulse latches the line-status source. A `lsr_read` pulse clears it; a simultaneous new error wins.
- R11: A `modem_delta` pulse latches the modem source. A `msr_read` pulse clears it; a simultaneous new change wins.
- R12: After reset, with `fifo_on` at 0 and no source active, `ident` is 8'h01 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_err | input | 1 | Pulse: receive line error detected |
| lsr_read | input | 1 | Pulse: line status register read |
| rx_ready | input | 1 | Level: received data available |
| hold_empty | input | 1 | Level: transmit holding register empty |
| hold_write | input | 1 | Pulse: transmit holding register written |
| modem_delta | input | 1 | Pulse: modem status input changed |
| msr_read | input | 1 | Pulse: modem status register read |
| int_en | input | 4 | Interrupt enable field |
| fifo_on | input | 1 | FIFOs enabled |
| out2 | input | 1 | Interrupt output gate |
| ident_read | input | 1 | Pulse: identification byte read |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest state to reach is a transmit-empty source that is pending or cleared independently of the `hold_empty` level. It is set by edges and cleared by two different acknowledges. Before every pattern the bench writes the holding register with `hold_empty` low, which puts the source in a known cleared state. It then raises `hold_empty` to produce a fresh edge only when the pattern asks for it. This lets the sweep cover all sixteen source combinations under all enables, gate and FIFO settings. Directed sequences then reach the acknowledge-by-read case and the enable-edge case with `hold_empty` held high.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_err,
  input  logic       lsr_read,
  input  logic       rx_ready,
  input  logic       hold_empty,
  input  logic       hold_write,
  input  logic       modem_delta,
  input  logic       msr_read,
  input  logic [3:0] int_en,
  input  logic       fifo_on,
  input  logic       out2,
  input  logic       ident_read,
  output logic [7:0] ident,
  output logic       irq
);

  logic ls_q, ms_q, th_q, empty_q, th_en_q;
  logic [1:0] code;

  wire       empty_rise = hold_empty & ~empty_q;
  wire       en_rise    = int_en[1] & ~th_en_q & hold_empty;
  wire [3:0] act        = int_en & {ms_q, ls_q, th_q, rx_ready};
  wire       pend       = |act;
  wire       th_shown   = pend && (code == 2'b01);

  always_comb begin
    if (act[2])      code = 2'b11;
    else if (act[0]) code = 2'b10;
    else if (act[1]) code = 2'b01;
    else             code = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q    <= 1'b0;
      ms_q    <= 1'b0;
      th_q    <= 1'b0;
      empty_q <= 1'b1;
      th_en_q <= 1'b0;
    end else begin
      ls_q    <= line_err | (ls_q & ~lsr_read);
      ms_q    <= modem_delta | (ms_q & ~msr_read);
      th_q    <= empty_rise | en_rise |
                 (th_q & ~hold_write & ~(ident_read & th_shown));
      empty_q <= hold_empty;
      th_en_q <= int_en[1];
    end
  end

  assign ident = {{2{fifo_on}}, 3'b000, code, ~pend};
  assign irq   = out2 & pend;

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out2 && !ident[0]));

  // R4
  rx_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && int_en[0]) |-> (!ident[0] && ident[2]));

  // R8
  hold_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_write && !hold_empty) |=> (ident[2:0] != 3'b010));

  // R10
  ls_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !line_err) |=> (ident[2:0] != 3'b110));

  // R11
  ms_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_read && !modem_delta) |=> (ident[2:0] != 3'b000));

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_err = 0, lsr_read = 0, rx_ready = 0, hold_empty = 0, hold_write = 0;
  logic modem_delta = 0, msr_read = 0, fifo_on = 0, out2 = 0, ident_read = 0;
  logic [3:0] int_en = 4'h0;
  logic [7:0] ident;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .line_err(line_err), .lsr_read(lsr_read),
    .rx_ready(rx_ready), .hold_empty(hold_empty), .hold_write(hold_write),
    .modem_delta(modem_delta), .msr_read(msr_read), .int_en(int_en),
    .fifo_on(fifo_on), .out2(out2), .ident_read(ident_read),
    .ident(ident), .irq(irq));

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_pulses();
    line_err = 0; lsr_read = 0; hold_write = 0;
    modem_delta = 0; msr_read = 0; ident_read = 0;
  endtask

  function automatic logic [8:0] model(input logic ls, input logic rx,
      input logic th, input logic ms, input logic [3:0] en,
      input logic f, input logic o);
    logic [1:0] c;
    logic p;
    p = 1'b1;
    if (ls && en[2])      c = 2'b11;
    else if (rx && en[0]) c = 2'b10;
    else if (th && en[1]) c = 2'b01;
    else if (ms && en[3]) c = 2'b00;
    else begin c = 2'b00; p = 1'b0; end
    return {o & p, f, f, 3'b000, c, ~p};
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12 reset state
    check("R12", {irq, ident}, 9'h001);
    rst_n = 1'b1;
    step();
    check("R12", {irq, ident}, 9'h001);

    // R1 R2 R3 R4 R5 R6 R8 R10 R11 exhaustive sweep
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        for (int g = 0; g < 4; g++) begin
          lsr_read = 1; msr_read = 1; hold_write = 1; hold_empty = 0;
          rx_ready = 0; int_en = 4'h0;
          step();
          drop_pulses();
          line_err = s[0]; rx_ready = s[1]; hold_empty = s[2]; modem_delta = s[3];
          int_en = e[3:0]; fifo_on = g[0]; out2 = g[1];
          step();
          drop_pulses();
          check("R1/R2/R3/R4/R5/R6", {irq, ident},
                model(s[0], s[1], s[2], s[3], e[3:0], g[0], g[1]));
        end
      end
    end

    // R7: read clears transmit-empty when it is the shown source
    fifo_on = 0; out2 = 1;
    lsr_read = 1; msr_read = 1; hold_write = 1; hold_empty = 0; rx_ready = 0; int_en = 0;
    step(); drop_pulses();
    hold_empty = 1; int_en = 4'b0110;
    step();
    check("R8", {irq, ident}, 9'h102);
    line_err = 1;
    step(); drop_pulses();
    check("R10", {irq, ident}, 9'h106);
    ident_read = 1;
    step(); drop_pulses();
    lsr_read = 1;
    step(); drop_pulses();
    check("R7 other source shown", {irq, ident}, 9'h102);
    ident_read = 1;
    step(); drop_pulses();
    check("R7 clear on read", {irq, ident}, 9'h001);
    step();
    check("R7 stays clear", {irq, ident}, 9'h001);

    // R9: enable edge while already empty
    int_en = 4'b0000;
    step();
    int_en = 4'b0010;
    step();
    check("R9", {irq, ident}, 9'h102);
    hold_write = 1;
    step(); drop_pulses();
    check("R8 write clears", {irq, ident}, 9'h001);

    // R10 / R11 set wins over clear
    int_en = 4'b1100;
    line_err = 1; lsr_read = 1;
    step(); drop_pulses();
    check("R10 set wins", {irq, ident}, 9'h106);
    lsr_read = 1;
    step(); drop_pulses();
    check("R10 clear", {irq, ident}, 9'h001);
    modem_delta = 1; msr_read = 1;
    step(); drop_pulses();
    check("R11 set wins", {irq, ident}, 9'h100);
    out2 = 0;
    step();
    check("R6 gate off", {irq, ident}, 9'h000);
    msr_read = 1;
    step(); drop_pulses();
    check("R11 clear", {irq, ident}, 9'h001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule